// File: doc/BRIEF.md
# Programmable Periodic Interrupt Timer

This block is a register-mapped interval timer that sits next to an interrupt controller. Software loads a 32-bit interval, counted in bus clock periods, and then writes the control register with the run bit set. The timer then requests an interrupt once per interval until software clears the run bit. The vector and the priority of that request are not wired to any fixed line. Both come from fields that software writes into the control register, so one timer can be attached to any vector. For one-shot use, software clears the run bit after the first request.

A read-only register reports how many nanoseconds one bus clock lasts, which lets software convert a time into an interval. The current down-counter value can be read back at any time. A build-time option selects a compatibility mapping for controllers that only accept vectors 64 to 127. In that mapping the priority is folded into the vector.

Control is a Moore state machine with three states. `ST_IDLE` means the timer is stopped. `ST_COUNT` means it is counting down. `ST_EXPIRE` is the single cycle in which a request is presented, and the counter is reloaded on entry to it.

The transitions are:
- Any control write with the run bit set goes to `ST_COUNT`.
- Any control write with the run bit clear goes to `ST_IDLE`.
- `ST_COUNT` or `ST_EXPIRE` goes to `ST_EXPIRE` when the counter is at one.
- `ST_COUNT` or `ST_EXPIRE` goes to `ST_COUNT` otherwise.
- `ST_IDLE` stays in `ST_IDLE`.

Top module: `tick_irq_timer`

## Requirements
- R1: After reset the timer is stopped. `irq_valid` is 0, and the control, interval and count registers all read 0.
- R2: The control register is at byte offset 0x00. Bit 26 is the run bit, bits 23:20 are the priority and bits 19:12 are the vector. Writing it with bit 26 set loads the counter with the interval. The first request appears N cycles after that write edge, and the request then repeats every N cycles.
- R3: For an interval of 2 or more, a request is a one-cycle pulse on `irq_valid`. During the pulse it carries the vector and priority latched by the last control write. While `irq_valid` is 0, `irq_vector` and `irq_level` are 0.
- R4: A control write with bit 26 clear stops the timer. No request follows it, and the count register reads 0.
- R5: An interval of 0 is treated as an interval of 1, which gives a request on every cycle.
- R6: The interval register is at offset 0x10 and reads back the 32-bit value written. A new interval written while the timer runs takes effect at the next reload and does not shorten the period already in progress.
- R7: The count register is at offset 0x14. It reads N right after an enabling write and then drops by one per cycle. Writes to it are ignored.
- R8: The bus-period register is at offset 0x18. It reads `BUS_PERIOD_NS`, and writes to it are ignored.
- R9: With `COMPAT_MAP=1` the vector is {2'b01, vec[5:0] | (prio<<2)}. With `COMPAT_MAP=0` the vector is passed through unchanged. In both modes `irq_level` equals the priority.
- R10: The control register reads back bit 26, bits 23:20 and bits 19:12 as written, with all other bits 0. Offsets that map to no register read 0.
- R11: An enabling control write while the timer runs restarts the full interval from that edge. An expiry that would have fallen on that same edge is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| irq_valid | output | 1 | Interrupt request pulse |
| irq_vector | output | 8 | Vector of the request |
| irq_level | output | 4 | Priority of the request |

## Verification
Read data is combinational, so every register value can be sampled within the same cycle in which its address is driven. A control write takes effect at the edge where it is presented. The count then reads N at the next falling edge and one less at each later one. A request for interval N is high during the cycle that follows the Nth rising edge after the enabling write, and it is high again every N edges after that. The bench drives every access at a falling edge, counts falling edges from the write, and compares `irq_valid`, the vector and the level at each falling edge against that schedule. In particular it checks the restart and interval-change cases, where the expected edge moves.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int DATA_W  = 32;
    localparam int VEC_W   = 8;
    localparam int PRI_W   = 4;
    localparam int EN_BIT  = 26;
    localparam int PRI_LSB = 20;
    localparam int VEC_LSB = 12;

    localparam int OFS_CTL  = 'h00;
    localparam int OFS_IVAL = 'h10;
    localparam int OFS_CNT  = 'h14;
    localparam int OFS_BPER = 'h18;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_COUNT  = 2'd1,
        ST_EXPIRE = 2'd2
    } tmr_state_t;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int ADDR_W        = 8,
    parameter int CNT_W         = 32,
    parameter int BUS_PERIOD_NS = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [CNT_W-1:0]  count_q,
    output logic              ctl_wr,
    output logic              ctl_wr_en,
    output logic [VEC_W-1:0]  ctl_vec_q,
    output logic [PRI_W-1:0]  ctl_pri_q,
    output logic [CNT_W-1:0]  interval_q
);
    logic ctl_en_q;
    logic ival_wr;
    logic rd;

    // Address decode: the full byte address is compared, so a misaligned
    // address matches no register.
    always_comb begin
        ctl_wr    = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_CTL));
        ival_wr   = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_IVAL));
        ctl_wr_en = bus_wdata[EN_BIT];
        rd        = bus_sel && !bus_wr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_en_q  <= 1'b0;
            ctl_pri_q <= '0;
            ctl_vec_q <= '0;
        end else if (ctl_wr) begin
            ctl_en_q  <= bus_wdata[EN_BIT];
            ctl_pri_q <= bus_wdata[PRI_LSB +: PRI_W];
            ctl_vec_q <= bus_wdata[VEC_LSB +: VEC_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            interval_q <= '0;
        end else if (ival_wr) begin
            interval_q <= CNT_W'(bus_wdata);
        end
    end

    // Read mux. Offsets not listed here return zero.
    always_comb begin
        bus_rdata = '0;
        if (rd) begin
            case (bus_addr)
                ADDR_W'(OFS_CTL): begin
                    bus_rdata[EN_BIT]               = ctl_en_q;
                    bus_rdata[PRI_LSB +: PRI_W]     = ctl_pri_q;
                    bus_rdata[VEC_LSB +: VEC_W]     = ctl_vec_q;
                end
                ADDR_W'(OFS_IVAL): bus_rdata = DATA_W'(interval_q);
                ADDR_W'(OFS_CNT):  bus_rdata = DATA_W'(count_q);
                ADDR_W'(OFS_BPER): bus_rdata = DATA_W'(BUS_PERIOD_NS);
                default:           bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic             ctl_wr_en,
    input  logic [CNT_W-1:0] interval_q,
    output logic [CNT_W-1:0] count_q,
    output logic             fire,
    output logic             running
);
    tmr_state_t       state_q, state_n;
    logic [CNT_W-1:0] cnt_n;
    logic [CNT_W-1:0] reload;

    // An interval of zero is run as an interval of one.
    always_comb reload = (interval_q == '0) ? CNT_W'(1) : interval_q;

    // Next-state and next-count logic. A control write takes priority over
    // an expiry that falls on the same edge.
    always_comb begin
        state_n = state_q;
        cnt_n   = count_q;
        if (ctl_wr) begin
            if (ctl_wr_en) begin
                state_n = ST_COUNT;
                cnt_n   = reload;
            end else begin
                state_n = ST_IDLE;
                cnt_n   = '0;
            end
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_n = ST_IDLE;
                    cnt_n   = '0;
                end
                ST_COUNT, ST_EXPIRE: begin
                    if (count_q <= CNT_W'(1)) begin
                        state_n = ST_EXPIRE;
                        cnt_n   = reload;
                    end else begin
                        state_n = ST_COUNT;
                        cnt_n   = count_q - CNT_W'(1);
                    end
                end
                default: begin
                    state_n = ST_IDLE;
                    cnt_n   = '0;
                end
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    // Down-counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= cnt_n;
    end

    // Moore outputs.
    always_comb begin
        fire    = (state_q == ST_EXPIRE);
        running = (state_q != ST_IDLE);
    end
endmodule

// File: rtl/tmr_irq_map.sv
module tmr_irq_map
    import tmr_pkg::*;
#(
    parameter int COMPAT_MAP = 0
) (
    input  logic             fire,
    input  logic [VEC_W-1:0] ctl_vec_q,
    input  logic [PRI_W-1:0] ctl_pri_q,
    output logic             irq_valid,
    output logic [VEC_W-1:0] irq_vector,
    output logic [PRI_W-1:0] irq_level
);
    logic [VEC_W-1:0] mapped;

    generate
        if (COMPAT_MAP != 0) begin : g_compat
            // Only the window 64..127 is reachable. The priority lands on
            // bits 5:2 of the vector.
            always_comb mapped = {2'b01, ctl_vec_q[VEC_W-3:0] | {ctl_pri_q, 2'b00}};
        end else begin : g_direct
            always_comb mapped = ctl_vec_q;
        end
    endgenerate

    always_comb begin
        irq_valid  = fire;
        irq_vector = fire ? mapped : '0;
        irq_level  = fire ? ctl_pri_q : '0;
    end
endmodule

// File: rtl/tick_irq_timer.sv
module tick_irq_timer
    import tmr_pkg::*;
#(
    parameter int ADDR_W        = 8,
    parameter int CNT_W         = 32,
    parameter int BUS_PERIOD_NS = 20,
    parameter int COMPAT_MAP    = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_valid,
    output logic [7:0]        irq_vector,
    output logic [3:0]        irq_level
);
    logic             ctl_wr;
    logic             ctl_wr_en;
    logic [VEC_W-1:0] ctl_vec_q;
    logic [PRI_W-1:0] ctl_pri_q;
    logic [CNT_W-1:0] interval_q;
    logic [CNT_W-1:0] count_q;
    logic             fire;
    logic             running;

    tmr_regs #(
        .ADDR_W       (ADDR_W),
        .CNT_W        (CNT_W),
        .BUS_PERIOD_NS(BUS_PERIOD_NS)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .count_q   (count_q),
        .ctl_wr    (ctl_wr),
        .ctl_wr_en (ctl_wr_en),
        .ctl_vec_q (ctl_vec_q),
        .ctl_pri_q (ctl_pri_q),
        .interval_q(interval_q)
    );

    tmr_core #(
        .CNT_W(CNT_W)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_wr    (ctl_wr),
        .ctl_wr_en (ctl_wr_en),
        .interval_q(interval_q),
        .count_q   (count_q),
        .fire      (fire),
        .running   (running)
    );

    tmr_irq_map #(
        .COMPAT_MAP(COMPAT_MAP)
    ) u_map (
        .fire      (fire),
        .ctl_vec_q (ctl_vec_q),
        .ctl_pri_q (ctl_pri_q),
        .irq_valid (irq_valid),
        .irq_vector(irq_vector),
        .irq_level (irq_level)
    );
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
    parameter int ADDR_W        = 8,
    parameter int CNT_W         = 32,
    parameter int BUS_PERIOD_NS = 20,
    parameter int COMPAT_MAP    = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              irq_valid,
    input logic [7:0]        irq_vector,
    input logic [3:0]        irq_level,
    input logic [CNT_W-1:0]  count_q,
    input logic [CNT_W-1:0]  interval_q,
    input logic              running
);
    logic wr_ctl;
    always_comb wr_ctl = bus_sel && bus_wr && (bus_addr == ADDR_W'(0));

    AST_RELOAD_ON_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && bus_wdata[26]) |=>
        (count_q == (($past(interval_q) == '0) ? CNT_W'(1) : $past(interval_q)))); // R2

    AST_EXPIRY_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !wr_ctl && count_q == CNT_W'(1)) |=> irq_valid); // R2

    AST_QUIET_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_valid |-> (irq_vector == 8'd0 && irq_level == 4'd0)); // R3

    AST_STOP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && !bus_wdata[26]) |=> (!irq_valid && count_q == '0)); // R4

    AST_IDLE_NO_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> !irq_valid); // R4

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !wr_ctl && count_q > CNT_W'(1)) |=>
        (count_q == $past(count_q) - CNT_W'(1))); // R7

    AST_BPER_CONST: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == ADDR_W'('h18)) |->
        (bus_rdata == 32'(BUS_PERIOD_NS))); // R8

    AST_COMPAT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && COMPAT_MAP != 0) |-> (irq_vector[7:6] == 2'b01)); // R9
endmodule

bind tick_irq_timer tmr_chk #(
    .ADDR_W       (ADDR_W),
    .CNT_W        (CNT_W),
    .BUS_PERIOD_NS(BUS_PERIOD_NS),
    .COMPAT_MAP   (COMPAT_MAP)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_valid (irq_valid),
    .irq_vector(irq_vector),
    .irq_level (irq_level),
    .count_q   (count_q),
    .interval_q(interval_q),
    .running   (running)
);

// File: tb/sim_tick_irq_timer.sv
module sim_tick_irq_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rdata0, rdata1;
    logic        v0, v1;
    logic [7:0]  vec0, vec1;
    logic [3:0]  lvl0, lvl1;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    tick_irq_timer #(.BUS_PERIOD_NS(20), .COMPAT_MAP(0)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata0),
        .irq_valid(v0), .irq_vector(vec0), .irq_level(lvl0));

    tick_irq_timer #(.BUS_PERIOD_NS(10), .COMPAT_MAP(1)) u1 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata1),
        .irq_valid(v1), .irq_vector(vec1), .irq_level(lvl1));

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // Called at a falling edge; the write lands on the next rising edge and
    // the task returns at the falling edge after it.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d0, output logic [31:0] d1);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d0 = rdata0; d1 = rdata1;
        bus_sel = 1'b0;
    endtask

    // Checks u0 from falling edge k_from to k_to after a write edge.
    // A request is expected at k = first, first+period, ...
    task automatic watch(input int first, input int period, input int k_from,
                         input int k_to, input logic [7:0] ev, input logic [3:0] el,
                         input string req);
        for (int k = k_from; k <= k_to; k++) begin
            bit exp;
            if (k > k_from) @(negedge clk);
            exp = (k >= first) && (((k - first) % period) == 0);
            chk(v0 == exp, req, $sformatf("irq_valid at edge %0d", k), v0, exp);
            chk(vec0 == (exp ? ev : 8'd0), "R3", $sformatf("vector at edge %0d", k),
                vec0, exp ? ev : 8'd0);
            chk(lvl0 == (exp ? el : 4'd0), "R3", $sformatf("level at edge %0d", k),
                lvl0, exp ? el : 4'd0);
        end
    endtask

    function automatic logic [31:0] ctlw(input bit en, input logic [3:0] p, input logic [7:0] v);
        return (32'(en) << 26) | (32'(p) << 20) | (32'(v) << 12);
    endfunction

    task automatic t_reset;
        logic [31:0] a, b;
        chk(v0 == 1'b0, "R1", "irq_valid after reset", v0, 0);
        rd(8'h00, a, b); chk(a == 0, "R1", "ctl after reset", a, 0);
        rd(8'h10, a, b); chk(a == 0, "R1", "interval after reset", a, 0);
        rd(8'h14, a, b); chk(a == 0, "R1", "count after reset", a, 0);
    endtask

    task automatic t_periodic;
        wr(8'h10, 32'd5);
        wr(8'h00, ctlw(1, 4'h7, 8'h9A));
        watch(5, 5, 0, 16, 8'h9A, 4'h7, "R2");
        wr(8'h00, 32'd0);
    endtask

    task automatic t_count;
        logic [31:0] a, b;
        wr(8'h10, 32'd9);
        wr(8'h00, ctlw(1, 4'h1, 8'h11));
        rd(8'h14, a, b); chk(a == 9, "R7", "count right after enable", a, 9);
        @(negedge clk);
        rd(8'h14, a, b); chk(a == 8, "R7", "count one cycle later", a, 8);
        wr(8'h14, 32'h55);
        rd(8'h14, a, b); chk(a == 7, "R7", "count after ignored write", a, 7);
        wr(8'h00, 32'd0);
    endtask

    task automatic t_stop;
        logic [31:0] a, b;
        wr(8'h10, 32'd3);
        wr(8'h00, ctlw(1, 4'h2, 8'h22));
        watch(3, 3, 0, 4, 8'h22, 4'h2, "R2");
        wr(8'h00, 32'd0);
        watch(1000, 1, 0, 20, 8'h00, 4'h0, "R4");
        rd(8'h14, a, b); chk(a == 0, "R4", "count after stop", a, 0);
    endtask

    task automatic t_zero;
        wr(8'h10, 32'd0);
        wr(8'h00, ctlw(1, 4'h3, 8'h33));
        watch(1, 1, 0, 6, 8'h33, 4'h3, "R5");
        wr(8'h00, 32'd0);
    endtask

    task automatic t_ival_change;
        logic [31:0] a, b;
        wr(8'h10, 32'd6);
        wr(8'h00, ctlw(1, 4'h4, 8'h44));
        wr(8'h10, 32'd3);
        rd(8'h10, a, b); chk(a == 3, "R6", "interval readback", a, 3);
        watch(6, 3, 1, 13, 8'h44, 4'h4, "R6");
        wr(8'h00, 32'd0);
    endtask

    task automatic t_restart;
        wr(8'h10, 32'd4);
        wr(8'h00, ctlw(1, 4'h5, 8'h55));
        watch(4, 4, 0, 3, 8'h55, 4'h5, "R11");
        wr(8'h00, ctlw(1, 4'h6, 8'h66));
        watch(4, 4, 0, 9, 8'h66, 4'h6, "R11");
        wr(8'h00, 32'd0);
    endtask

    task automatic t_bper;
        logic [31:0] a, b;
        rd(8'h18, a, b);
        chk(a == 20, "R8", "bus period u0", a, 20);
        chk(b == 10, "R8", "bus period u1", b, 10);
        wr(8'h18, 32'hFFFF);
        rd(8'h18, a, b);
        chk(a == 20, "R8", "bus period after write", a, 20);
    endtask

    task automatic t_ctl_rb;
        logic [31:0] a, b;
        wr(8'h00, 32'h0BAC_D123);
        rd(8'h00, a, b); chk(a == 32'h00AC_D000, "R10", "ctl readback, run clear", a, 32'h00AC_D000);
        wr(8'h00, 32'h07FF_FFFF);
        rd(8'h00, a, b); chk(a == 32'h04FF_F000, "R10", "ctl readback, run set", a, 32'h04FF_F000);
        rd(8'h08, a, b); chk(a == 0, "R10", "unmapped offset 0x08", a, 0);
        rd(8'h01, a, b); chk(a == 0, "R10", "misaligned offset 0x01", a, 0);
        wr(8'h00, 32'd0);
    endtask

    task automatic t_compat;
        wr(8'h10, 32'd3);
        wr(8'h00, ctlw(1, 4'hA, 8'hC5));
        for (int k = 0; k <= 7; k++) begin
            bit exp;
            if (k > 0) @(negedge clk);
            exp = (k > 0) && (k % 3 == 0);
            chk(v1 == exp, "R9", $sformatf("compat valid at edge %0d", k), v1, exp);
            if (exp) begin
                chk(vec1 == 8'h6D, "R9", "compat vector", vec1, 8'h6D);
                chk(lvl1 == 4'hA, "R9", "compat level", lvl1, 4'hA);
                chk(vec0 == 8'hC5, "R9", "direct vector", vec0, 8'hC5);
                chk(lvl0 == 4'hA, "R9", "direct level", lvl0, 4'hA);
            end
        end
        wr(8'h00, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_periodic();
        t_count();
        t_stop();
        t_zero();
        t_ival_change();
        t_restart();
        t_bper();
        t_ctl_rb();
        t_compat();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule